// File: doc/BRIEF.md
# Word-Wide Non-Volatile Memory Mode Controller

This block sequences word-level operations on a 32-word by 16-bit non-volatile store. It also holds a register model of the cell state. A host issues one of three requests, with a word address and, for writes, a data word:
- **Write** (`pgm_i`): erases the addressed word and then programs it.
- **Erase-only** (`ers_i`): clears the addressed word.
- **Read** (`rd_i`): returns the addressed word on a separate output bus.

Erase and program are long, fixed-length phases timed by a cycle counter. The default is 2304 cycles each, which is 1.2 ms at 1.92 MHz.

During a read the block steps three strobes through a fixed order:
1. The word-line select rises.
2. The control-gate drive rises.
3. The active-low sense enable falls, and the sensed word is captured into the output register.

`busy_o` covers every operation from acceptance to completion. `done_o` pulses once when an operation finishes.

Erased cells hold 0. Programming can only turn bits to 1, so a write always erases the whole word first. The charge pumps, bias levels, sense amplifier and physical cell are outside this block.

Top module: `nvm_word_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `done_o`, `row_sel_o`, `cg_o`, `erase_o` and `prog_o` are 0, `sense_en_no` is 1 and `dout_o` is 0.
- R2: A write request stores `din_i` exactly at `addr_i`, whatever the word held before. A later read returns `din_i`.
- R3: An erase-only request leaves the addressed word reading back as 16'h0000. No other word changes.
- R4: Each erase and program phase lasts PHASE_CYCLES cycles. `busy_o` stays high for 2*PHASE_CYCLES consecutive cycles on a write and PHASE_CYCLES on an erase-only, followed by a one-cycle `done_o` pulse.
- R5: During a write, `erase_o` is high for the first phase and `prog_o` for the second. They are never high together, and program never precedes erase.
- R6: A read is busy for exactly 3 cycles:
  - cycle 1: `row_sel_o` only;
  - cycle 2: `row_sel_o` and `cg_o`;
  - cycle 3: `row_sel_o`, `cg_o` and `sense_en_no` low.
  The word appears on `dout_o` as `busy_o` falls.
- R7: Requests that arrive while `busy_o` is high are ignored. The running operation keeps its address and data, and its length is unchanged.
- R8: Simultaneous requests are served with priority erase-only, then write, then read. Only one operation runs.
- R9: Asserting `rst_ni` low mid-operation aborts it at once and clears `dout_o`. Stored words are kept, except that a word whose erase phase already completed stays erased.
- R10: `dout_o` changes only at the end of a read. It holds its value while the address and data inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read request |
| ers_i | input | 1 | Erase-only request |
| pgm_i | input | 1 | Write request (erase then program) |
| addr_i | input | 5 | Word address |
| din_i | input | 16 | Write data |
| dout_o | output | 16 | Read data register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| row_sel_o | output | 1 | Word-line select strobe |
| cg_o | output | 1 | Control-gate drive strobe |
| sense_en_no | output | 1 | Active-low sense enable |
| erase_o | output | 1 | Erase phase drive |
| prog_o | output | 1 | Program phase drive |

## Verification
The hardest situation to reach is a reset that lands inside a long phase. Whether the word survives depends on which side of the erase/program boundary the reset falls. The bench counts falling edges from acceptance and drops `rst_ni` once mid-erase and once mid-program. It then reads both words back through the normal read path.

Requests landing mid-operation and simultaneous request combinations are also driven on exact cycles. The bench uses a short phase length so that every address can be written and read back.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_RD_ROW,
    ST_RD_CG,
    ST_RD_SENSE
  } nvm_state_e;
endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
  parameter int PHASE_CYCLES = 2304
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(PHASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);  // R4
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));  // R4
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             clr_we_i,
  input  logic             set_we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] set_data_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [WORDS];

  // contents survive reset: no reset branch
  always_ff @(posedge clk_i) begin
    if (clr_we_i)      mem_q[addr_i] <= '0;
    else if (set_we_i) mem_q[addr_i] <= mem_q[addr_i] | set_data_i;
  end

  assign rd_data_o = mem_q[addr_i];

  always_comb begin
    AST_SINGLE_WRITE: assert (!(clr_we_i && set_we_i));  // R5
  end
endmodule

// File: rtl/nvm_sequencer.sv
module nvm_sequencer
  import nvm_ctrl_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             ers_i,
  input  logic             pgm_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             expire_i,
  input  logic [WIDTH-1:0] rd_data_i,
  output logic             run_o,
  output logic             clr_we_o,
  output logic             set_we_o,
  output logic [AW-1:0]    addr_o,
  output logic [WIDTH-1:0] set_data_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             row_sel_o,
  output logic             cg_o,
  output logic             sense_en_no,
  output logic             erase_o,
  output logic             prog_o
);
  nvm_state_e       state_q;
  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] din_q;
  logic [WIDTH-1:0] dout_q;
  logic             erase_only_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      din_q        <= '0;
      dout_q       <= '0;
      erase_only_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // priority: erase-only, write, read
          if (ers_i) begin
            state_q      <= ST_ERASE;
            erase_only_q <= 1'b1;
            addr_q       <= addr_i;
          end else if (pgm_i) begin
            state_q      <= ST_ERASE;
            erase_only_q <= 1'b0;
            addr_q       <= addr_i;
            din_q        <= din_i;
          end else if (rd_i) begin
            state_q <= ST_RD_ROW;
            addr_q  <= addr_i;
          end
        end
        ST_ERASE: if (expire_i) begin
          if (erase_only_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_PROG;
          end
        end
        ST_PROG: if (expire_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        ST_RD_ROW: state_q <= ST_RD_CG;
        ST_RD_CG:  state_q <= ST_RD_SENSE;
        ST_RD_SENSE: begin
          dout_q  <= rd_data_i;
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o       = (state_q == ST_ERASE) || (state_q == ST_PROG);
  assign clr_we_o    = (state_q == ST_ERASE) && expire_i;
  assign set_we_o    = (state_q == ST_PROG) && expire_i;
  assign addr_o      = addr_q;
  assign set_data_o  = din_q;
  assign dout_o      = dout_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign erase_o     = (state_q == ST_ERASE);
  assign prog_o      = (state_q == ST_PROG);
  assign row_sel_o   = (state_q == ST_RD_ROW) || (state_q == ST_RD_CG) ||
                       (state_q == ST_RD_SENSE);
  assign cg_o        = (state_q == ST_RD_CG) || (state_q == ST_RD_SENSE);
  assign sense_en_no = (state_q != ST_RD_SENSE);

  AST_CG_NEEDS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cg_o |-> row_sel_o);  // R6
  AST_SENSE_NEEDS_CG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sense_en_no |-> (cg_o && $past(cg_o)));  // R6
  AST_ROW_BEFORE_CG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cg_o) |-> $past(row_sel_o));  // R6
  AST_ERASE_BEFORE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(erase_o));  // R5
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_o && prog_o));  // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (rd_i || ers_i || pgm_i)) |=> busy_o);  // R8
  AST_BUSY_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_q));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);  // R4
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_en_no |=> $stable(dout_o));  // R10
endmodule

// File: rtl/nvm_word_ctrl.sv
module nvm_word_ctrl #(
  parameter int WORDS        = 32,
  parameter int WIDTH        = 16,
  parameter int PHASE_CYCLES = 2304,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             ers_i,
  input  logic             pgm_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             row_sel_o,
  output logic             cg_o,
  output logic             sense_en_no,
  output logic             erase_o,
  output logic             prog_o
);
  logic             run, expire, clr_we, set_we;
  logic [AW-1:0]    cell_addr;
  logic [WIDTH-1:0] set_data, rd_data;

  nvm_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .expire_o (expire)
  );

  nvm_cell_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
    .clk_i      (clk_i),
    .clr_we_i   (clr_we),
    .set_we_i   (set_we),
    .addr_i     (cell_addr),
    .set_data_i (set_data),
    .rd_data_o  (rd_data)
  );

  nvm_sequencer #(.WORDS(WORDS), .WIDTH(WIDTH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .ers_i       (ers_i),
    .pgm_i       (pgm_i),
    .addr_i      (addr_i),
    .din_i       (din_i),
    .expire_i    (expire),
    .rd_data_i   (rd_data),
    .run_o       (run),
    .clr_we_o    (clr_we),
    .set_we_o    (set_we),
    .addr_o      (cell_addr),
    .set_data_o  (set_data),
    .dout_o      (dout_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .row_sel_o   (row_sel_o),
    .cg_o        (cg_o),
    .sense_en_no (sense_en_no),
    .erase_o     (erase_o),
    .prog_o      (prog_o)
  );
endmodule

// File: tb/tb_nvm_word_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_word_ctrl;
  localparam int WORDS = 32;
  localparam int WIDTH = 16;
  localparam int PH    = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd = 1'b0, ers = 1'b0, pgm = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic busy, done, row_sel, cg, sense_en_n, erase_drv, prog_drv;

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [15:0] model [WORDS];

  always #2 clk = ~clk;

  nvm_word_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH), .PHASE_CYCLES(PH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd), .ers_i(ers), .pgm_i(pgm),
    .addr_i(addr), .din_i(din), .dout_o(dout), .busy_o(busy), .done_o(done),
    .row_sel_o(row_sel), .cg_o(cg), .sense_en_no(sense_en_n),
    .erase_o(erase_drv), .prog_o(prog_drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int salt);
    return 16'((a * 32'h9E37 + salt * 32'h5A1) ^ (a << 11));
  endfunction

  // drive one request cycle, then run to completion sampling at negedges
  task automatic run_op(input logic e, input logic p, input logic r,
                        input logic [4:0] a, input logic [15:0] d,
                        output int blen, output int ecnt, output int pcnt,
                        output int order_bad, output logic [8:0] rcode,
                        output logic dn);
    ers = e; pgm = p; rd = r; addr = a; din = d;
    @(negedge clk);
    ers = 0; pgm = 0; rd = 0;
    blen = 0; ecnt = 0; pcnt = 0; order_bad = 0; rcode = '0;
    while (busy && blen < 5000) begin
      blen++;
      if (erase_drv) begin ecnt++; if (pcnt != 0) order_bad++; end
      if (prog_drv) pcnt++;
      if (erase_drv && prog_drv) order_bad++;
      rcode = {rcode[5:0], row_sel, cg, ~sense_en_n};
      @(negedge clk);
    end
    dn = done;
  endtask

  task automatic do_read(input logic [4:0] a, input string req);
    int bl, ec, pc, ob; logic [8:0] rc; logic dn;
    run_op(0, 0, 1, a, 16'h0, bl, ec, pc, ob, rc, dn);
    chk(dout === model[a], req, int'(dout), int'(model[a]));
  endtask

  initial begin
    #150000;
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int bl, ec, pc, ob; logic [8:0] rc; logic dn;
    logic [15:0] hold;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({busy, done, row_sel, cg, erase_drv, prog_drv, sense_en_n} === 7'b0000001,
        "R1 strobes in reset", {busy, done, row_sel, cg, erase_drv, prog_drv, sense_en_n}, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(dout === 16'h0 && !busy && !done, "R1 after release", int'(dout), 0);

    // R2 R4 R5 write sweep over every address
    for (int a = 0; a < WORDS; a++) begin
      model[a] = pat(a, 1);
      run_op(0, 1, 0, 5'(a), model[a], bl, ec, pc, ob, rc, dn);
      chk(bl == 2 * PH && dn === 1'b1, "R4 write busy length", bl, 2 * PH);
      chk(ec == PH && pc == PH && ob == 0, "R5 erase then program", ec * 256 + pc, PH * 256 + PH);
    end
    // R6 read sweep
    for (int a = 0; a < WORDS; a++) begin
      run_op(0, 0, 1, 5'(a), 16'h0, bl, ec, pc, ob, rc, dn);
      chk(bl == 3 && rc === 9'b100_110_111 && dn === 1'b1, "R6 read strobe order", int'(rc), 9'b100_110_111);
      chk(dout === model[a], "R2 read back", int'(dout), int'(model[a]));
    end

    // R2 overwrite clears bits that were 1
    model[7] = ~model[7] & 16'h0F0F;
    run_op(0, 1, 0, 5'd7, model[7], bl, ec, pc, ob, rc, dn);
    do_read(5'd7, "R2 overwrite exact");

    // R3 R4 erase-only
    run_op(1, 0, 0, 5'd5, 16'hFFFF, bl, ec, pc, ob, rc, dn);
    chk(bl == PH && pc == 0 && dn === 1'b1, "R4 erase-only length", bl, PH);
    model[5] = 16'h0;
    do_read(5'd5, "R3 erased word is zero");
    do_read(5'd6, "R3 neighbour untouched");

    // R7 requests during busy ignored
    pgm = 1; addr = 5'd3; din = 16'hC3A5; model[3] = 16'hC3A5;
    @(negedge clk); pgm = 0;
    bl = 1;
    @(negedge clk); bl++;
    ers = 1; addr = 5'd4; din = 16'h1111;
    @(negedge clk); bl++; ers = 0; rd = 1; pgm = 1;
    @(negedge clk); bl++; rd = 0; pgm = 0;
    while (busy && bl < 5000) begin bl++; @(negedge clk); end
    chk(bl == 2 * PH + 1, "R7 busy length unchanged", bl - 1, 2 * PH);
    do_read(5'd4, "R7 ignored erase left word");
    do_read(5'd3, "R7 running write kept data");

    // R8 priority
    run_op(1, 1, 1, 5'd9, 16'hABCD, bl, ec, pc, ob, rc, dn);
    chk(bl == PH && pc == 0, "R8 erase beats write", bl, PH);
    model[9] = 16'h0;
    do_read(5'd9, "R8 erase result");
    run_op(0, 1, 1, 5'd12, 16'h5AA5, bl, ec, pc, ob, rc, dn);
    chk(bl == 2 * PH, "R8 write beats read", bl, 2 * PH);
    model[12] = 16'h5AA5;
    do_read(5'd12, "R8 write result");

    // R9 reset during erase phase keeps word
    do_read(5'd10, "R9 pre-read");
    pgm = 1; addr = 5'd10; din = ~model[10];
    @(negedge clk); pgm = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0; #1;
    chk(!busy && !erase_drv && dout === 16'h0, "R9 abort clears", {busy, erase_drv, dout}, 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    do_read(5'd10, "R9 reset mid-erase keeps word");
    // R9 reset during program phase: word already erased
    pgm = 1; addr = 5'd11; din = 16'hFFFF;
    @(negedge clk); pgm = 0;
    repeat (PH + 3) @(negedge clk);
    chk(prog_drv === 1'b1, "R9 in program phase", prog_drv, 1);
    rst_ni = 1'b0; #1;
    chk(!busy && !prog_drv, "R9 program abort", {busy, prog_drv}, 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    model[11] = 16'h0;
    do_read(5'd11, "R9 reset mid-program leaves erased");

    // R10 dout holds while inputs move
    do_read(5'd2, "R10 read");
    hold = dout;
    for (int i = 0; i < 6; i++) begin
      addr = 5'(i * 7); din = 16'(i * 16'h1357);
      @(negedge clk);
      chk(dout === hold, "R10 dout stable", int'(dout), int'(hold));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule